// File: doc/BRIEF.md
# NAND Small-Page Read Sequencer

This block drives a small-page NAND flash device through a byte-wide command, address and data bus. A single start pulse with a two-bit operation code launches one of three transactions: a device reset, a page read, or a check of a block's bad-block marker. The block then runs the whole exchange without further help. It asserts chip enable, sends the command and address bytes, waits for the device's busy period to end, collects the data, and finally releases chip enable and raises a one-cycle completion pulse that carries a pass or fail result.

On a page read, the main-area bytes are forwarded on a byte stream as they arrive. Three spare-area bytes are compared with an error-code value that another block computes from the same data. The bad-block check reads a single marker byte from page 0 of the chosen block. Every wait for the device is bounded by a cycle limit. If the device never signals ready, the transaction is abandoned and reported as failed.

Top module: `nand_page_reader`

## Requirements
- R1: While reset is asserted and right after it is released, nf_ce_n is 1, busy, done, out_valid and all three bus strobes are 0, and nf_io_out is 0.
- R2: Operation codes are 2'b00 device reset, 2'b01 page read and 2'b10 bad-block check. A start with code 2'b11 has no effect: busy and every bus strobe stay low.
- R3: A start seen while busy is 1 is ignored, and the running transaction continues unchanged.
- R4: A page read drives, in consecutive cycles starting in the cycle after the accepted start, nf_cmd_stb with byte 0x00, then nf_addr_stb with bytes 0x00, row[7:0], row[15:8] and row[23:16], where row = blk*32 + (pg mod 32).
- R5: A bad-block check drives nf_cmd_stb with 0x50, then nf_addr_stb with 0x05, then the three row bytes (low first) of row = blk*32.
- R6: A device reset drives nf_cmd_stb with 0xFF for one cycle, then waits for ready. When ready rises, done is raised with pass = 1.
- R7: The wait starts in the cycle after the last command or address byte. It ends only in a cycle of the wait in which nf_rdy is 1 after having been 0 in the previous cycle. A ready line that stays high does not end it.
- R8: After a page read's wait ends, nf_rd_stb is high for 528 consecutive cycles and nf_io_in is sampled in each of them. The first 512 samples appear on out_data with out_valid high, each one cycle after its strobe.
- R9: A page read passes only if read bytes 512, 513 and 514 equal ecc_ref[7:0], ecc_ref[15:8] and ecc_ref[23:16].
- R10: A bad-block check reads one byte with a single nf_rd_stb cycle, and passes (block good) only if that byte is 0xFF.
- R11: In the cycle after the last read strobe, or after the ready rise for a reset, done is 1 for exactly one cycle with the result on pass. In the same cycle busy is 0 and nf_ce_n is 1. nf_ce_n is 0 from the cycle after the accepted start until then.
- R12: If no ready rise occurs within TMO_CYC wait cycles, the next cycle has done = 1, pass = 0 and nf_ce_n = 1, and no read strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch pulse |
| op | input | 2 | Operation code |
| blk | input | BLK_W | Block number |
| pg | input | PG_W | Page number; only the low 5 bits are used |
| ecc_ref | input | 24 | Expected spare bytes 0..2, lowest byte first |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result, valid with done |
| out_valid | output | 1 | out_data holds a main-area byte |
| out_data | output | 8 | Streamed main-area byte |
| nf_ce_n | output | 1 | Device chip enable, active low |
| nf_cmd_stb | output | 1 | nf_io_out carries a command byte |
| nf_addr_stb | output | 1 | nf_io_out carries an address byte |
| nf_rd_stb | output | 1 | Read cycle; nf_io_in is sampled |
| nf_io_out | output | 8 | Command or address byte |
| nf_io_in | input | 8 | Data byte from the device |
| nf_rdy | input | 1 | Device ready (1) or busy (0) |

## Verification
The bench goes after the wait boundaries. A device whose ready line never drops must time out, because a design that accepts a level instead of a rise would read stale data. A ready line stuck low must also time out, because a design without the limit would hang with chip enable held low. A one-cycle busy pulse must still be caught. Page numbers above 31 test the row packing, which an unmasked design would corrupt in the block bits. A fault in one spare byte of the ECC must fail the read, which catches a comparison that ignores a byte or takes the wrong one. Bad-block markers of 0xFF, 0x00 and 0xFE separate an exact comparison from a test of a single bit. A start pulse in the middle of a transaction and a start with code 2'b11 must both leave the bus sequence untouched.

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int BLK_W       = 12,
  parameter int PG_W        = 8,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int TMO_CYC     = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       op,
  input  logic [BLK_W-1:0] blk,
  input  logic [PG_W-1:0]  pg,
  input  logic [23:0]      ecc_ref,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             nf_ce_n,
  output logic             nf_cmd_stb,
  output logic             nf_addr_stb,
  output logic             nf_rd_stb,
  output logic [7:0]       nf_io_out,
  input  logic [7:0]       nf_io_in,
  input  logic             nf_rdy
);
  localparam int TOTAL = MAIN_BYTES + SPARE_BYTES;
  localparam int CNT_W = $clog2(TOTAL);
  localparam int TMO_W = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;
  localparam logic [1:0] OP_RST  = 2'b00;
  localparam logic [1:0] OP_READ = 2'b01;
  localparam logic [1:0] OP_BAD  = 2'b10;
  localparam logic [7:0] COL_BAD = 8'((MAIN_BYTES + 5) & 15);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_WAIT, S_DATA} st_t;

  st_t              st;
  logic [1:0]       op_q;
  logic [23:0]      row_q;
  logic [1:0]       aidx;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmr;
  logic             rdy_q;
  logic [23:0]      spare_q;
  logic [7:0]       cmd_byte;
  logic [7:0]       addr_byte;

  wire go       = start && (op != 2'b11) && (st == S_IDLE);
  wire rdy_rise = nf_rdy && !rdy_q;
  wire [CNT_W-1:0] last_idx = (op_q == OP_READ) ? CNT_W'(TOTAL - 1) : '0;

  assign cmd_byte = (op_q == OP_RST) ? 8'hFF : (op_q == OP_BAD) ? 8'h50 : 8'h00;

  always_comb begin
    case (aidx)
      2'd0:    addr_byte = (op_q == OP_BAD) ? COL_BAD : 8'h00;
      2'd1:    addr_byte = row_q[7:0];
      2'd2:    addr_byte = row_q[15:8];
      default: addr_byte = row_q[23:16];
    endcase
  end

  assign busy        = (st != S_IDLE);
  assign nf_cmd_stb  = (st == S_CMD);
  assign nf_addr_stb = (st == S_ADDR);
  assign nf_rd_stb   = (st == S_DATA);
  assign nf_io_out   = (st == S_CMD) ? cmd_byte : (st == S_ADDR) ? addr_byte : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      op_q      <= OP_RST;
      row_q     <= '0;
      aidx      <= '0;
      cnt       <= '0;
      tmr       <= '0;
      rdy_q     <= 1'b1;
      spare_q   <= '0;
      nf_ce_n   <= 1'b1;
      done      <= 1'b0;
      pass      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      rdy_q     <= nf_rdy;
      done      <= 1'b0;
      out_valid <= 1'b0;
      case (st)
        S_IDLE: if (go) begin
          st      <= S_CMD;
          op_q    <= op;
          row_q   <= (op == OP_BAD) ? 24'({blk, 5'd0}) : 24'({blk, pg[4:0]});
          nf_ce_n <= 1'b0;
        end
        S_CMD: begin
          aidx <= '0;
          tmr  <= '0;
          st   <= (op_q == OP_RST) ? S_WAIT : S_ADDR;
        end
        S_ADDR: begin
          aidx <= aidx + 2'd1;
          if (aidx == 2'd3) st <= S_WAIT;
        end
        S_WAIT: begin
          if (rdy_rise) begin
            if (op_q == OP_RST) begin
              st      <= S_IDLE;
              nf_ce_n <= 1'b1;
              done    <= 1'b1;
              pass    <= 1'b1;
            end else begin
              st  <= S_DATA;
              cnt <= '0;
            end
          end else if (tmr == TMO_W'(TMO_CYC - 1)) begin
            st      <= S_IDLE;
            nf_ce_n <= 1'b1;
            done    <= 1'b1;
            pass    <= 1'b0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_DATA: begin
          cnt <= cnt + 1'b1;
          if (op_q == OP_READ && cnt < CNT_W'(MAIN_BYTES)) begin
            out_valid <= 1'b1;
            out_data  <= nf_io_in;
          end
          for (int k = 0; k < 3; k++)
            if (op_q == OP_READ && cnt == CNT_W'(MAIN_BYTES + k)) spare_q[8*k +: 8] <= nf_io_in;
          if (cnt == last_idx) begin
            st      <= S_IDLE;
            nf_ce_n <= 1'b1;
            done    <= 1'b1;
            pass    <= (op_q == OP_READ) ? (spare_q == ecc_ref) : (nf_io_in == 8'hFF);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  idle_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> nf_ce_n);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  out_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n) out_valid |-> $past(nf_rd_stb));
  // R8
  read_under_ce_chk: assert property (@(posedge clk) disable iff (!rst_n) nf_rd_stb |-> !nf_ce_n);
  // R7
  read_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_rd_stb && !$past(nf_rd_stb)) |-> ($past(nf_rdy) && !$past(nf_rdy, 2)));
  // R12
  done_releases_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (nf_ce_n && !busy));
endmodule

// File: tb/test_nand_page_reader.sv
module test_nand_page_reader;
  localparam int CLK_NS = 10;
  localparam int TMO    = 64;

  logic clk = 0, rst_n = 0, start = 0, nf_rdy = 1;
  logic [1:0] op = 0;
  logic [11:0] blk = 0;
  logic [7:0] pg = 0, nf_io_in = 0;
  logic [23:0] ecc_ref = 0;
  logic busy, done, pass, out_valid, nf_ce_n, nf_cmd_stb, nf_addr_stb, nf_rd_stb;
  logic [7:0] out_data, nf_io_out;

  nand_page_reader #(.BLK_W(12), .PG_W(8), .MAIN_BYTES(512), .SPARE_BYTES(16), .TMO_CYC(TMO)) i_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .blk(blk), .pg(pg), .ecc_ref(ecc_ref),
    .busy(busy), .done(done), .pass(pass), .out_valid(out_valid), .out_data(out_data),
    .nf_ce_n(nf_ce_n), .nf_cmd_stb(nf_cmd_stb), .nf_addr_stb(nf_addr_stb), .nf_rd_stb(nf_rd_stb),
    .nf_io_out(nf_io_out), .nf_io_in(nf_io_in), .nf_rdy(nf_rdy));

  always #(CLK_NS/2) clk = ~clk;

  int vectors = 0, miscompares = 0, cyc = 0;
  string ph_tag = "R1";
  bit bad_vec;

  // flash device model
  int dev_mode = 0, dev_busy = 10;
  logic [7:0] bad_val = 8'hFF;
  logic [23:0] cur_row = 0;
  int d_dly = 0, d_bsy = 0, d_naddr = 0, d_ridx = 0;
  bit d_armed = 0, d_badm = 0;

  function automatic logic [7:0] dat(input logic [23:0] row, input int k);
    return 8'(row[7:0] + row[15:8] + k * 3 + (k >> 3));
  endfunction

  always @(posedge clk) begin
    logic c, a, r;
    logic [7:0] b;
    bit arm;
    c = nf_cmd_stb; a = nf_addr_stb; r = nf_rd_stb; b = nf_io_out;
    arm = 0;
    #1;
    if (c) begin d_naddr = 0; d_ridx = 0; d_badm = (b == 8'h50); if (b == 8'hFF) arm = 1; end
    if (a) begin d_naddr++; if (d_naddr == 4) arm = 1; end
    if (r) d_ridx++;
    if (arm && dev_mode != 1) begin
      d_armed = 1; d_dly = 2; d_bsy = (dev_mode == 2) ? 1000000 : dev_busy;
    end else if (dev_mode == 1) begin
      d_armed = 0; nf_rdy = 1;
    end else if (d_armed) begin
      if (d_dly > 0) d_dly--;
      else if (d_bsy > 0) begin nf_rdy = 0; d_bsy--; end
      else begin nf_rdy = 1; d_armed = 0; end
    end
    nf_io_in = d_badm ? bad_val : dat(cur_row, d_ridx);
  end

  // reference model, compared on every falling edge
  int m_ph = 0, m_w = 0, m_r = 0, m_nr = 0;
  int m_op = 0;
  logic [9:0] m_q[$];
  logic [7:0] m_sp[3];
  logic m_done = 0, m_pass = 0, m_ov = 0, m_rdy_q = 1, m_to = 0;
  logic [7:0] m_od = 0;

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string sig, input string rq);
    if (got !== exp) begin
      bad_vec = 1;
      $display("FAIL %s [%s] %s: actual %0h expected %0h", rq, ph_tag, sig, got, exp);
    end
  endtask

  task automatic fin(input logic p, input logic to);
    m_ph = 0; m_done = 1; m_pass = p; m_to = to;
  endtask

  always @(negedge clk) begin
    string sq, rt, dt, pt;
    logic rise, p;
    logic [23:0] row;
    cyc++;
    if (!rst_n) begin
      bad_vec = 0; vectors++;
      chk(8'(nf_ce_n), 8'd1, "nf_ce_n", "R1");
      chk(8'(busy), 8'd0, "busy", "R1");
      chk(8'(done), 8'd0, "done", "R1");
      chk(8'(out_valid), 8'd0, "out_valid", "R1");
      chk(8'({nf_cmd_stb, nf_addr_stb, nf_rd_stb}), 8'd0, "strobes", "R1");
      chk(nf_io_out, 8'd0, "nf_io_out", "R1");
      if (bad_vec) miscompares++;
      m_ph = 0; m_q.delete(); m_done = 0; m_ov = 0; m_rdy_q = 1; m_to = 0;
    end else begin
      sq = (m_op == 0) ? "R6" : (m_op == 1) ? "R4" : "R5";
      rt = (m_ph == 3) ? ((m_op == 2) ? "R10" : "R8") : "R7";
      dt = m_to ? "R12" : "R11";
      pt = m_to ? "R12" : (m_op == 0) ? "R6" : (m_op == 1) ? "R9" : "R10";
      bad_vec = 0; vectors++;
      chk(8'(nf_ce_n), 8'(m_ph == 0 && 1'b1), "nf_ce_n", "R11");
      chk(8'(busy), 8'(m_ph != 0), "busy", "R11");
      chk(8'(nf_cmd_stb), 8'(m_ph == 1 && m_q[0][9]), "nf_cmd_stb", sq);
      chk(8'(nf_addr_stb), 8'(m_ph == 1 && m_q[0][8]), "nf_addr_stb", sq);
      chk(nf_io_out, (m_ph == 1) ? m_q[0][7:0] : 8'h00, "nf_io_out", sq);
      chk(8'(nf_rd_stb), 8'(m_ph == 3), "nf_rd_stb", rt);
      chk(8'(out_valid), 8'(m_ov), "out_valid", "R8");
      if (m_ov) chk(out_data, m_od, "out_data", "R8");
      chk(8'(done), 8'(m_done), "done", dt);
      if (m_done) chk(8'(pass), 8'(m_pass), "pass", pt);
      if (bad_vec) miscompares++;
      // advance
      m_done = 0; m_ov = 0;
      rise = nf_rdy && !m_rdy_q;
      m_rdy_q = nf_rdy;
      case (m_ph)
        0: if (start && op != 2'b11) begin
          m_op = op; m_to = 0; m_q.delete();
          row = (op == 2'b10) ? 24'(blk) * 32 : 24'(blk) * 32 + 24'(pg % 32);
          if (op == 2'b00) m_q.push_back({2'b10, 8'hFF});
          else begin
            m_q.push_back({2'b10, (op == 2'b10) ? 8'h50 : 8'h00});
            m_q.push_back({2'b01, (op == 2'b10) ? 8'h05 : 8'h00});
            m_q.push_back({2'b01, row[7:0]});
            m_q.push_back({2'b01, row[15:8]});
            m_q.push_back({2'b01, row[23:16]});
          end
          m_ph = 1;
        end
        1: begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_ph = 2; m_w = 0; end
        end
        2: if (rise) begin
          if (m_op == 0) fin(1'b1, 1'b0);
          else begin m_ph = 3; m_r = 0; m_nr = (m_op == 1) ? 528 : 1; end
        end else if (m_w == TMO - 1) fin(1'b0, 1'b1);
        else m_w++;
        3: begin
          if (m_op == 1) begin
            if (m_r < 512) begin m_ov = 1; m_od = nf_io_in; end
            else if (m_r < 515) m_sp[m_r - 512] = nf_io_in;
          end
          if (m_r == m_nr - 1) begin
            p = (m_op == 1) ? ({m_sp[2], m_sp[1], m_sp[0]} == ecc_ref) : (nf_io_in == 8'hFF);
            fin(p, 1'b0);
          end else m_r++;
        end
        default: m_ph = 0;
      endcase
    end
    if (cyc > 150000) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic launch(input logic [1:0] o, input logic [11:0] b, input logic [7:0] p);
    @(posedge clk); #1;
    start = 1; op = o; blk = b; pg = p;
    cur_row = 24'(b) * 32 + 24'(p % 32);
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic wait_idle();
    @(posedge clk);
    while (m_ph != 0) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic good_ecc(input logic [11:0] b, input logic [7:0] p);
    logic [23:0] r;
    r = 24'(b) * 32 + 24'(p % 32);
    ecc_ref = {dat(r, 514), dat(r, 513), dat(r, 512)};
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(posedge clk);
    ph_tag = "R6";  launch(2'b00, 0, 0); wait_idle();
    ph_tag = "R4";  good_ecc(12'h123, 8'h2A); launch(2'b01, 12'h123, 8'h2A); wait_idle();
    ph_tag = "R9";  good_ecc(12'h045, 8'h03); ecc_ref ^= 24'h000100;
    launch(2'b01, 12'h045, 8'h03); wait_idle();
    ph_tag = "R9";  good_ecc(12'hFFF, 8'hFF); launch(2'b01, 12'hFFF, 8'hFF); wait_idle();
    ph_tag = "R10"; bad_val = 8'hFF; launch(2'b10, 12'h2B7, 8'h11); wait_idle();
    ph_tag = "R10"; bad_val = 8'h00; launch(2'b10, 12'h2B8, 8'h00); wait_idle();
    ph_tag = "R10"; bad_val = 8'hFE; launch(2'b10, 12'h001, 8'h00); wait_idle();
    ph_tag = "R2";  launch(2'b11, 12'h0AA, 8'h05); wait_idle();
    ph_tag = "R3";  good_ecc(12'h300, 8'h07); launch(2'b01, 12'h300, 8'h07);
    repeat (8) @(posedge clk); #1 start = 1; op = 2'b10;
    @(posedge clk); #1 start = 0;
    wait_idle();
    ph_tag = "R7";  dev_busy = 1; bad_val = 8'hFF; launch(2'b10, 12'h010, 8'h00); wait_idle();
    dev_busy = 10;
    ph_tag = "R12"; dev_mode = 1; launch(2'b01, 12'h020, 8'h01); wait_idle();
    ph_tag = "R12"; dev_mode = 2; launch(2'b10, 12'h021, 8'h00); wait_idle();
    ph_tag = "R12"; launch(2'b00, 0, 0); wait_idle();
    ph_tag = "R6";  dev_mode = 0; launch(2'b00, 0, 0); wait_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule